// File: doc/BRIEF.md
# Open-Row Preferring Request Scheduler

This block holds a small queue of memory read and write requests in front of a DRAM controller and decides which one goes out next. For each bank it keeps the row that was opened last. A queued request whose row is already open in its bank is a hit. The block issues hits first, even when a hit is younger than the oldest waiting request. This raises the share of accesses that find their row already open.

Skipping the oldest request cannot go on without end. A counter records how many times a younger request has been issued ahead of the current oldest entry. When that count reaches a configured allowance, the scheduler stops reordering and issues the oldest entry next. The allowance is chosen from a small set of values. One code means "automatic" and selects the largest allowance. No setting turns the allowance off. Requests enter through a valid/ready port, and they leave through a second valid/ready port that carries the address, the direction flag and the tag.

Top module: `rq_hit_arbiter`

## Requirements
- R1: After synchronous reset the queue is empty (`out_valid` low, `in_ready` high), every bank has no open row, the skip count is zero and the allowance is 16.
- R2: `in_ready` is low exactly when 8 requests are queued. An accepted request can be issued from the next cycle on. An enqueue and an issue in the same cycle are both taken.
- R3: The address is laid out as column in bits [5:0], bank in bits [7:6] and row in bits [15:8]. Each issued request leaves its row recorded as open for its bank. A request is a hit when its bank has a recorded row equal to its own row.
- R4: When the allowance has not been reached, the oldest hit is issued. If no request is a hit, the oldest request is issued.
- R5: The skip count goes up by one for each issue of a request other than the oldest. It returns to zero whenever the oldest request is issued.
- R6: When the skip count has reached the allowance, the oldest request is issued whatever the hits are. The count never exceeds the allowance.
- R7: `cfg_lim` codes select the allowance as follows: 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, and 0 (automatic) and 5 to 7 give 16. No code yields zero.
- R8: `cfg_lim` is taken in only on cycles when the queue is empty. Changes while requests are queued have no effect until the queue has drained.
- R9: Requests that are not issued keep their relative age order. The next oldest becomes the oldest when the head leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lim | input | 3 | Skip allowance code |
| in_valid | input | 1 | Enqueue request present |
| in_ready | output | 1 | Queue can accept a request |
| in_addr | input | 16 | Request address (row, bank, column) |
| in_write | input | 1 | 1 for write, 0 for read |
| in_tag | input | 4 | Request identifier |
| out_valid | output | 1 | A request is offered for issue |
| out_ready | input | 1 | Downstream takes the offered request |
| out_addr | output | 16 | Address of the offered request |
| out_write | output | 1 | Direction of the offered request |
| out_tag | output | 4 | Identifier of the offered request |

## Verification
The assertions check these properties on every cycle:
- the queue refuses input when it is full;
- a request other than the oldest leaves only if it is a hit;
- the skip count stays within the allowance and steps or clears correctly on each issue;
- the oldest request is forced out at the allowance;
- the allowance is always one of the four legal values and never moves while requests are queued.

Some behaviour can only be seen in the bench's scenarios, because a reference model must follow whole request streams. This covers which hit is the oldest, how open rows carry across issues, the order of the requests left behind, and the mapping from each `cfg_lim` code to when forcing starts.

// File: rtl/rq_pkg.sv
package rq_pkg;
    parameter int ADDR_W = 16;
    parameter int COL_W  = 6;
    parameter int BANK_W = 2;
    parameter int ROW_W  = 8;
    parameter int TAG_W  = 4;
    parameter int DEPTH  = 8;
    parameter int CFG_W  = 3;
    parameter int MAX_LIM = 16;

    localparam int NBANK = 1 << BANK_W;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BYP_W = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [TAG_W-1:0]  tag;
    } req_t;

    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        return a[COL_W +: BANK_W];
    endfunction

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[COL_W+BANK_W +: ROW_W];
    endfunction

    function automatic logic [BYP_W-1:0] limit_of(input logic [CFG_W-1:0] c);
        case (c)
            3'd1:    return BYP_W'(2);
            3'd2:    return BYP_W'(4);
            3'd3:    return BYP_W'(8);
            default: return BYP_W'(MAX_LIM);
        endcase
    endfunction
endpackage

// File: rtl/rq_store.sv
module rq_store
    import rq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  req_t             push_req,
    input  logic             pop,
    input  logic [IDX_W-1:0] pop_idx,
    output req_t             slot [DEPTH],
    output logic [DEPTH-1:0] vld,
    output logic [CNT_W-1:0] count
);
    req_t             slot_q [DEPTH];
    req_t             slot_n [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_n;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) slot_n[i] = slot_q[i];
        count_n = count_q;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) slot_n[i] = slot_q[i+1];
            end
            count_n = count_q - 1'b1;
        end
        if (push) begin
            slot_n[count_n[IDX_W-1:0]] = push_req;
            count_n = count_n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            count_q <= count_n;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_out
            assign slot[g] = slot_q[g];
            assign vld[g]  = (count_q > CNT_W'(g));
        end
    endgenerate

    assign count = count_q;
endmodule

// File: rtl/rq_rowtab.sv
module rq_rowtab
    import rq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [ADDR_W-1:0] upd_addr,
    input  req_t              slot [DEPTH],
    input  logic [DEPTH-1:0]  vld,
    output logic [DEPTH-1:0]  hit
);
    logic [NBANK-1:0] open_v;
    logic [ROW_W-1:0] open_row [NBANK];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_v <= '0;
            for (int b = 0; b < NBANK; b++) open_row[b] <= '0;
        end else if (upd) begin
            open_v[bank_of(upd_addr)]   <= 1'b1;
            open_row[bank_of(upd_addr)] <= row_of(upd_addr);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hit
            assign hit[g] = vld[g] && open_v[bank_of(slot[g].addr)]
                          && (open_row[bank_of(slot[g].addr)] == row_of(slot[g].addr));
        end
    endgenerate
endmodule

// File: rtl/rq_select.sv
module rq_select
    import rq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg,
    input  logic             empty,
    input  logic [DEPTH-1:0] hit,
    input  logic             fire,
    output logic [IDX_W-1:0] sel_idx,
    output logic [BYP_W-1:0] byp_cnt,
    output logic [BYP_W-1:0] lim
);
    logic [BYP_W-1:0] byp_q;
    logic [BYP_W-1:0] lim_q;
    logic             found;
    logic [IDX_W-1:0] first_hit;
    logic             force_old;

    always_comb begin
        found     = 1'b0;
        first_hit = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found     = 1'b1;
                first_hit = IDX_W'(i);
            end
        end
    end

    assign force_old = (byp_q >= lim_q);
    assign sel_idx   = (force_old || !found) ? '0 : first_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= '0;
            lim_q <= BYP_W'(MAX_LIM);
        end else begin
            if (empty) lim_q <= limit_of(cfg);
            if (fire) byp_q <= (sel_idx == '0) ? '0 : byp_q + 1'b1;
        end
    end

    assign byp_cnt = byp_q;
    assign lim     = lim_q;
endmodule

// File: rtl/rq_hit_arbiter.sv
module rq_hit_arbiter
    import rq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_lim,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic [TAG_W-1:0]  out_tag
);
    req_t             slot [DEPTH];
    req_t             in_req;
    req_t             cur;
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] hit;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] sel_idx;
    logic [BYP_W-1:0] byp_cnt;
    logic [BYP_W-1:0] lim;
    logic             push;
    logic             fire;

    assign in_req    = '{addr: in_addr, wr: in_write, tag: in_tag};
    assign in_ready  = (count != CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign push      = in_valid && in_ready;
    assign fire      = out_valid && out_ready;
    assign cur       = slot[sel_idx];
    assign out_addr  = cur.addr;
    assign out_write = cur.wr;
    assign out_tag   = cur.tag;

    rq_store u_store (
        .clk(clk), .rst(rst), .push(push), .push_req(in_req),
        .pop(fire), .pop_idx(sel_idx), .slot(slot), .vld(vld), .count(count)
    );

    rq_rowtab u_rows (
        .clk(clk), .rst(rst), .upd(fire), .upd_addr(cur.addr),
        .slot(slot), .vld(vld), .hit(hit)
    );

    rq_select u_sel (
        .clk(clk), .rst(rst), .cfg(cfg_lim), .empty(count == '0),
        .hit(hit), .fire(fire), .sel_idx(sel_idx), .byp_cnt(byp_cnt), .lim(lim)
    );
endmodule

// File: rtl/rq_hit_arbiter_chk.sv
module rq_hit_arbiter_chk
    import rq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] count,
    input logic [IDX_W-1:0] sel_idx,
    input logic [DEPTH-1:0] hit,
    input logic [BYP_W-1:0] byp_cnt,
    input logic [BYP_W-1:0] lim
);
    // R2
    full_blocks_enq_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !in_ready);

    // R4
    young_is_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sel_idx != '0) |-> hit[sel_idx]);

    // R6
    byp_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        byp_cnt <= lim);

    // R6
    force_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && byp_cnt >= lim) |-> (sel_idx == '0));

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && sel_idx == '0) |=> (byp_cnt == '0));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && sel_idx != '0) |=> (byp_cnt == BYP_W'($past(byp_cnt) + 1'b1)));

    // R7
    lim_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (lim == 5'd2 || lim == 5'd4 || lim == 5'd8 || lim == 5'd16));

    // R8
    lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |=> $stable(lim));
endmodule

bind rq_hit_arbiter rq_hit_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .count(count), .sel_idx(sel_idx), .hit(hit),
    .byp_cnt(byp_cnt), .lim(lim)
);

// File: tb/tb_rq_hit_arbiter.sv
module tb_rq_hit_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_lim = 3'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic        in_write = 1'b0;
    logic [3:0]  in_tag = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_addr;
    logic        out_write;
    logic [3:0]  out_tag;

    always #10 clk = ~clk;

    rq_hit_arbiter dut (
        .clk(clk), .rst(rst), .cfg_lim(cfg_lim), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_write(in_write), .in_tag(in_tag), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_write(out_write), .out_tag(out_tag)
    );

    typedef struct { int addr; int wr; int tag; } mreq_t;
    mreq_t mq[$];
    int    orow [4];
    bit    oval [4];
    int    bcnt, mlim, tagc;
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;

    function automatic int lim_for(int c);
        case (c)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pick();
        if (bcnt >= mlim) return 0;
        foreach (mq[i]) begin
            int b = (mq[i].addr >> 6) & 3;
            int r = (mq[i].addr >> 8) & 255;
            if (oval[b] && orow[b] == r) return i;
        end
        return 0;
    endfunction

    // One cycle: compare, drive, advance model. Called at negedge.
    task automatic step(string req, int cfg, int bmod, int rmod, int in_pct, int out_pct);
        int  sel;
        bit  push, pop;
        chk(in_ready == (mq.size() < 8), "R2", "in_ready", in_ready, mq.size() < 8);
        chk(out_valid == (mq.size() > 0), "R2", "out_valid", out_valid, mq.size() > 0);
        sel = 0;
        if (mq.size() > 0) begin
            sel = pick();
            chk(out_tag == 4'(mq[sel].tag), req, "out_tag", out_tag, mq[sel].tag);
            chk(out_addr == 16'(mq[sel].addr), req, "out_addr", out_addr, mq[sel].addr);
            chk(out_write == mq[sel].wr[0], req, "out_write", out_write, mq[sel].wr);
        end
        cfg_lim   = (cfg < 0) ? 3'($urandom_range(0, 7)) : 3'(cfg);
        in_valid  = ($urandom_range(0, 99) < in_pct);
        in_addr   = 16'(($urandom_range(0, rmod - 1) << 8) | ($urandom_range(0, bmod - 1) << 6)
                        | $urandom_range(0, 63));
        in_write  = $urandom_range(0, 1) == 1;
        in_tag    = 4'(tagc);
        out_ready = ($urandom_range(0, 99) < out_pct);
        push = in_valid && (mq.size() < 8);
        pop  = out_ready && (mq.size() > 0);
        if (mq.size() == 0) mlim = lim_for(int'(cfg_lim));
        if (pop) begin
            oval[(mq[sel].addr >> 6) & 3] = 1'b1;
            orow[(mq[sel].addr >> 6) & 3] = (mq[sel].addr >> 8) & 255;
            bcnt = (sel == 0) ? 0 : bcnt + 1;
            mq.delete(sel);
        end
        if (push) begin
            mq.push_back('{addr: int'(in_addr), wr: int'(in_write), tag: tagc});
            tagc = (tagc + 1) % 16;
        end
        @(negedge clk);
    endtask

    task automatic run(string req, int n, int cfg, int bmod, int rmod, int in_pct, int out_pct);
        for (int k = 0; k < n; k++) step(req, cfg, bmod, rmod, in_pct, out_pct);
    endtask

    task automatic drain(string req, int cfg);
        run(req, 12, cfg, 1, 1, 0, 100);
    endtask

    initial begin
        bcnt = 0; mlim = 16; tagc = 0;
        for (int b = 0; b < 4; b++) begin oval[b] = 1'b0; orow[b] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        run("R1", 20, 0, 4, 4, 50, 50);
        // R2: fill to full, then enqueue and issue together
        run("R2", 12, 0, 4, 4, 100, 0);
        run("R2", 30, 0, 4, 4, 100, 100);
        drain("R2", 0);
        // R3: bank/row layout and open-row tracking
        run("R3", 300, 0, 4, 2, 70, 50);
        drain("R3", 0);
        // R4: oldest hit first, oldest otherwise
        run("R4", 400, 0, 2, 3, 70, 50);
        drain("R4", 1);
        // R5 / R6: small allowance, frequent skips
        run("R5", 300, 1, 1, 2, 80, 40);
        run("R6", 300, 1, 1, 3, 90, 30);
        drain("R6", 0);
        // R7: every code, with a drain between so the code is taken in
        for (int c = 0; c < 8; c++) begin
            drain("R7", c);
            run("R7", 150, c, 1, 2, 85, 40);
        end
        drain("R8", 2);
        // R8: code changes every cycle while queued
        run("R8", 400, -1, 1, 2, 80, 45);
        drain("R8", -1);
        // R9: order among requests left behind
        run("R9", 400, 3, 2, 4, 75, 55);
        drain("R9", 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule